// File: doc/BRIEF.md
# Block-Granular RAM Write Guard

This block stands between the write paths into on-chip RAM and the RAM itself. It gates the RAM write enable for each write. The RAM address space is cut into 32-byte blocks, and each block owns one write-protect bit in a bitmap that software loads through a small register port. A write from the CPU port in user (unprivileged) mode that lands in a protected block is dropped and answered at once with a bus error. Privileged CPU writes and all reads always go through.

A set of peripheral DMA write ports is checked against the same bitmap, but only when a control bit enables it. When a DMA write hits a protected block, the write is dropped. The block latches the byte address and the port index of the first such fault and raises a level interrupt. Both stay in place until software clears a sticky status bit by writing 1 to it. The decisions are combinational, so an allowed write reaches the RAM in the same cycle it is presented.

Top module: `ram_wprot_guard`

## Requirements
- R1: The block index is address bits [ADDR_W-1:5], so bits [4:0] play no part. Config address r, for r < NUM_REGS, holds bitmap word r, and bit b of that word protects block 32*r+b. The word reads back what was written.
- R2: A CPU write (cpu_req_i=1, cpu_we_i=1) with cpu_priv_i=0 to a block whose bit is 1 gives cpu_ram_we_o=0 and cpu_err_o=1 in the same cycle.
- R3: A user-mode CPU write to a block whose bit is 0 gives cpu_ram_we_o=1 and cpu_err_o=0 in the same cycle.
- R4: A CPU write with cpu_priv_i=1 gives cpu_ram_we_o=1 and cpu_err_o=0 for every block, whatever the bitmap holds.
- R5: A CPU read (cpu_we_i=0) never gives cpu_err_o=1 or cpu_ram_we_o=1, in either mode.
- R6: Bit 0 of the control word at config address NUM_REGS enables DMA checking, and it reads back. While it is 0, dma_ram_we_o equals dma_req_i and no fault is recorded.
- R7: While checking is enabled, a DMA write to a protected block gives a low dma_ram_we_o bit for that port in the same cycle. From the next cycle irq_o=1 and status bit 0 (config address NUM_REGS+1) reads 1. A write to an unprotected block passes.
- R8: A DMA fault that is accepted captures the full byte address, readable at config address NUM_REGS+2, and the port index, readable at NUM_REGS+3. When several ports fault in one cycle, the lowest index is captured.
- R9: While status bit 0 is set, later DMA faults leave the capture unchanged and irq_o stays 1. Writing 1 to status bit 0 clears it. If a fault arrives in the same cycle as the clear, that fault is captured and the status stays set.
- R10: After reset the bitmap, control, status and capture words read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_addr_i | input | CFG_AW | Config register word address |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_rdata_o | output | 32 | Config read data for cfg_addr_i (combinational) |
| cpu_req_i | input | 1 | CPU RAM access valid |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_priv_i | input | 1 | CPU access is privileged |
| cpu_addr_i | input | ADDR_W | CPU RAM byte address |
| cpu_ram_we_o | output | 1 | RAM write enable for the CPU access |
| cpu_err_o | output | 1 | Bus error response for a refused CPU write |
| dma_req_i | input | NUM_DMA | DMA write request per port |
| dma_addr_i | input | NUM_DMA*ADDR_W | DMA byte addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| dma_ram_we_o | output | NUM_DMA | RAM write enable per DMA port |
| irq_o | output | 1 | DMA protection fault interrupt |

## Verification
The bench builds the guard with ADDR_W=11 and NUM_DMA=3. That gives 64 blocks in two bitmap words, so every block can be swept for each CPU mode and access type. Every block is also swept on the DMA path, with checking disabled and then enabled. A fault is cleared after each sweep step, so each block's capture of address and port index is checked on its own. The small port count makes simultaneous faults, repeat faults under the sticky bit, and a clear colliding with a new fault easy to set up and predict.

// File: rtl/ramwp_pkg.sv
package ramwp_pkg;
  localparam int BLK_SHIFT = 5;
  localparam int WORD_W    = 32;

  function automatic int ctrl_off(int nregs);
    return nregs;
  endfunction
  function automatic int stat_off(int nregs);
    return nregs + 1;
  endfunction
  function automatic int faddr_off(int nregs);
    return nregs + 2;
  endfunction
  function automatic int fid_off(int nregs);
    return nregs + 3;
  endfunction
endpackage

// File: rtl/ramwp_bitmap.sv
module ramwp_bitmap
  import ramwp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NUM_LK = 2,
  parameter int CFG_AW = 4,
  localparam int BLK_W    = ADDR_W - BLK_SHIFT,
  localparam int NUM_BLK  = 1 << BLK_W,
  localparam int NUM_REGS = NUM_BLK / WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [CFG_AW-1:0]        cfg_addr_i,
  input  logic [WORD_W-1:0]        cfg_wdata_i,
  output logic [WORD_W-1:0]        rd_word_o,
  output logic                     rd_hit_o,
  input  logic [NUM_LK*ADDR_W-1:0] lk_addr_i,
  output logic [NUM_LK-1:0]        lk_prot_o
);
  logic [NUM_BLK-1:0] bm_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bm_q[r*WORD_W +: WORD_W] <= '0;
      end else if (cfg_we_i && cfg_addr_i == CFG_AW'(r)) begin
        bm_q[r*WORD_W +: WORD_W] <= cfg_wdata_i;
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    rd_hit_o  = 1'b0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (cfg_addr_i == CFG_AW'(r)) begin
        rd_word_o = bm_q[r*WORD_W +: WORD_W];
        rd_hit_o  = 1'b1;
      end
    end
  end

  for (genvar l = 0; l < NUM_LK; l++) begin : g_lk
    logic [BLK_W-1:0] blk;
    assign blk          = lk_addr_i[l*ADDR_W + BLK_SHIFT +: BLK_W];
    assign lk_prot_o[l] = bm_q[blk];
  end
endmodule

// File: rtl/ramwp_fault_cap.sv
module ramwp_fault_cap #(
  parameter int ADDR_W  = 13,
  parameter int NUM_DMA = 4,
  parameter int ID_W    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_DMA-1:0]        fault_i,
  input  logic [NUM_DMA*ADDR_W-1:0] addr_i,
  input  logic                      clr_i,
  output logic                      sticky_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [ID_W-1:0]           id_o
);
  logic              sticky_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic              hit;
  logic [ADDR_W-1:0] sel_addr;
  logic [ID_W-1:0]   sel_id;
  logic              capture;

  // descending scan: lowest faulting port wins
  always_comb begin
    hit      = 1'b0;
    sel_addr = '0;
    sel_id   = '0;
    for (int i = NUM_DMA - 1; i >= 0; i--) begin
      if (fault_i[i]) begin
        hit      = 1'b1;
        sel_addr = addr_i[i*ADDR_W +: ADDR_W];
        sel_id   = ID_W'(i);
      end
    end
  end

  assign capture = hit && (!sticky_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
      addr_q   <= '0;
      id_q     <= '0;
    end else begin
      sticky_q <= (sticky_q && !clr_i) || hit;
      if (capture) begin
        addr_q <= sel_addr;
        id_q   <= sel_id;
      end
    end
  end

  assign sticky_o = sticky_q;
  assign addr_o   = addr_q;
  assign id_o     = id_q;
endmodule

// File: rtl/ram_wprot_guard.sv
module ram_wprot_guard
  import ramwp_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int NUM_DMA = 4,
  localparam int BLK_W     = ADDR_W - BLK_SHIFT,
  localparam int NUM_BLK   = 1 << BLK_W,
  localparam int NUM_REGS  = NUM_BLK / WORD_W,
  localparam int CFG_AW    = $clog2(NUM_REGS + 4),
  localparam int ID_W      = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1,
  localparam int CTRL_OFF  = ctrl_off(NUM_REGS),
  localparam int STAT_OFF  = stat_off(NUM_REGS),
  localparam int FADDR_OFF = faddr_off(NUM_REGS),
  localparam int FID_OFF   = fid_off(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [CFG_AW-1:0]         cfg_addr_i,
  input  logic [31:0]               cfg_wdata_i,
  output logic [31:0]               cfg_rdata_o,
  input  logic                      cpu_req_i,
  input  logic                      cpu_we_i,
  input  logic                      cpu_priv_i,
  input  logic [ADDR_W-1:0]         cpu_addr_i,
  output logic                      cpu_ram_we_o,
  output logic                      cpu_err_o,
  input  logic [NUM_DMA-1:0]        dma_req_i,
  input  logic [NUM_DMA*ADDR_W-1:0] dma_addr_i,
  output logic [NUM_DMA-1:0]        dma_ram_we_o,
  output logic                      irq_o
);
  localparam int NUM_LK = NUM_DMA + 1;

  logic [NUM_LK*ADDR_W-1:0] lk_addr;
  logic [NUM_LK-1:0]        lk_prot;
  logic [WORD_W-1:0]        bm_word;
  logic                     bm_hit;
  logic                     dma_chk_en_q;
  logic [NUM_DMA-1:0]       dma_fault;
  logic                     stat_clr;
  logic                     sticky;
  logic [ADDR_W-1:0]        fault_addr;
  logic [ID_W-1:0]          fault_id;
  logic                     cpu_wr;
  logic                     cpu_block;

  // lookup slot 0 is the CPU, slots 1.. are DMA ports
  assign lk_addr = {dma_addr_i, cpu_addr_i};

  ramwp_bitmap #(
    .ADDR_W (ADDR_W),
    .NUM_LK (NUM_LK),
    .CFG_AW (CFG_AW)
  ) u_bitmap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .rd_word_o   (bm_word),
    .rd_hit_o    (bm_hit),
    .lk_addr_i   (lk_addr),
    .lk_prot_o   (lk_prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_chk_en_q <= 1'b0;
    end else if (cfg_we_i && cfg_addr_i == CFG_AW'(CTRL_OFF)) begin
      dma_chk_en_q <= cfg_wdata_i[0];
    end
  end

  assign stat_clr = cfg_we_i && (cfg_addr_i == CFG_AW'(STAT_OFF)) && cfg_wdata_i[0];

  // CPU path
  assign cpu_wr       = cpu_req_i && cpu_we_i;
  assign cpu_block    = cpu_wr && !cpu_priv_i && lk_prot[0];
  assign cpu_ram_we_o = cpu_wr && !cpu_block;
  assign cpu_err_o    = cpu_block;

  // DMA path
  for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma
    assign dma_fault[i]    = dma_req_i[i] && dma_chk_en_q && lk_prot[i+1];
    assign dma_ram_we_o[i] = dma_req_i[i] && !dma_fault[i];
  end

  ramwp_fault_cap #(
    .ADDR_W  (ADDR_W),
    .NUM_DMA (NUM_DMA),
    .ID_W    (ID_W)
  ) u_fault (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (dma_fault),
    .addr_i   (dma_addr_i),
    .clr_i    (stat_clr),
    .sticky_o (sticky),
    .addr_o   (fault_addr),
    .id_o     (fault_id)
  );

  assign irq_o = sticky;

  always_comb begin
    cfg_rdata_o = '0;
    if (bm_hit) begin
      cfg_rdata_o = bm_word;
    end else if (cfg_addr_i == CFG_AW'(CTRL_OFF)) begin
      cfg_rdata_o[0] = dma_chk_en_q;
    end else if (cfg_addr_i == CFG_AW'(STAT_OFF)) begin
      cfg_rdata_o[0] = sticky;
    end else if (cfg_addr_i == CFG_AW'(FADDR_OFF)) begin
      cfg_rdata_o[ADDR_W-1:0] = fault_addr;
    end else if (cfg_addr_i == CFG_AW'(FID_OFF)) begin
      cfg_rdata_o[ID_W-1:0] = fault_id;
    end
  end
endmodule

// File: rtl/ramwp_guard_chk.sv
module ramwp_guard_chk #(
  parameter int ADDR_W   = 13,
  parameter int NUM_DMA  = 4,
  parameter int CFG_AW   = 4,
  parameter int ID_W     = 2,
  parameter int STAT_OFF = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [CFG_AW-1:0]  cfg_addr_i,
  input logic               cfg_wbit0,
  input logic               cpu_req_i,
  input logic               cpu_we_i,
  input logic               cpu_priv_i,
  input logic               cpu_ram_we_o,
  input logic               cpu_err_o,
  input logic [NUM_DMA-1:0] dma_req_i,
  input logic [NUM_DMA-1:0] dma_ram_we_o,
  input logic               dma_en,
  input logic               irq_o,
  input logic [ADDR_W-1:0]  faddr,
  input logic [ID_W-1:0]    fid
);
  logic clr;
  assign clr = cfg_we_i && (cfg_addr_i == CFG_AW'(STAT_OFF)) && cfg_wbit0;

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_err_o |-> !cpu_ram_we_o && !cpu_priv_i && cpu_we_i); // R2
  AST_PRIV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && cpu_priv_i |-> cpu_ram_we_o && !cpu_err_o); // R4
  AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |-> !cpu_err_o && !cpu_ram_we_o); // R5
  AST_DMA_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en |-> dma_ram_we_o == dma_req_i); // R6
  AST_DMA_NO_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ram_we_o & ~dma_req_i) == '0); // R7
  AST_BLOCK_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_i & ~dma_ram_we_o) != '0 |=> irq_o); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr |=> irq_o); // R9
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr |=> $stable(faddr) && $stable(fid)); // R9
endmodule

bind ram_wprot_guard ramwp_guard_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_DMA  (NUM_DMA),
  .CFG_AW   (CFG_AW),
  .ID_W     (ID_W),
  .STAT_OFF (STAT_OFF)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_wbit0    (cfg_wdata_i[0]),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_priv_i   (cpu_priv_i),
  .cpu_ram_we_o (cpu_ram_we_o),
  .cpu_err_o    (cpu_err_o),
  .dma_req_i    (dma_req_i),
  .dma_ram_we_o (dma_ram_we_o),
  .dma_en       (dma_chk_en_q),
  .irq_o        (irq_o),
  .faddr        (fault_addr),
  .fid          (fault_id)
);

// File: tb/tb_ram_wprot_guard.sv
module tb_ram_wprot_guard;
  localparam int AW    = 11;
  localparam int ND    = 3;
  localparam int NBLK  = 64;
  localparam int NREG  = 2;
  localparam int CAW   = 3;
  localparam int CTRL  = NREG;
  localparam int STAT  = NREG + 1;
  localparam int FADDR = NREG + 2;
  localparam int FID   = NREG + 3;
  localparam logic [31:0] PAT0 = 32'hA5C3_0F96;
  localparam logic [31:0] PAT1 = 32'h1234_8001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_priv = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_ram_we, cpu_err;
  logic [ND-1:0] dma_req = '0;
  logic [ND*AW-1:0] dma_addr = '0;
  logic [ND-1:0] dma_ram_we;
  logic irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [31:0] rd;
  logic [63:0] pat;

  always #10 clk = ~clk;

  ram_wprot_guard #(.ADDR_W(AW), .NUM_DMA(ND)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_priv_i(cpu_priv), .cpu_addr_i(cpu_addr),
    .cpu_ram_we_o(cpu_ram_we), .cpu_err_o(cpu_err),
    .dma_req_i(dma_req), .dma_addr_i(dma_addr), .dma_ram_we_o(dma_ram_we), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cfg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = CAW'(a);
    #2 d = cfg_rdata;
  endtask

  function automatic logic [AW-1:0] blk_addr(input int blk);
    return AW'(blk * 32 + ((blk * 13) % 32));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    pat = {PAT1, PAT0};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    for (int a = 0; a < NREG + 4; a++) begin
      cfg_rd(a, rd);
      chk("R10 reset word", rd, 32'h0);
    end
    chk("R10 reset irq", {31'h0, irq}, 32'h0);

    // R1 bitmap load and readback
    cfg_wr(0, PAT0);
    cfg_wr(1, PAT1);
    cfg_rd(0, rd); chk("R1 word0", rd, PAT0);
    cfg_rd(1, rd); chk("R1 word1", rd, PAT1);

    // R2 R3 R4 R5 CPU sweep over all blocks
    for (int blk = 0; blk < NBLK; blk++) begin
      logic p;
      p = pat[blk];
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_priv = 1'b0; cpu_addr = blk_addr(blk);
      #2;
      if (p) begin
        chk("R2 user wr prot we", {31'h0, cpu_ram_we}, 32'h0);
        chk("R2 user wr prot err", {31'h0, cpu_err}, 32'h1);
      end else begin
        chk("R3 user wr open we", {31'h0, cpu_ram_we}, 32'h1);
        chk("R3 user wr open err", {31'h0, cpu_err}, 32'h0);
      end
      cpu_priv = 1'b1;
      #2;
      chk("R4 priv wr", {30'h0, cpu_ram_we, cpu_err}, 32'h2);
      cpu_we = 1'b0; cpu_priv = 1'b0;
      #2;
      chk("R5 user rd", {30'h0, cpu_ram_we, cpu_err}, 32'h0);
      cpu_priv = 1'b1;
      #2;
      chk("R5 priv rd", {30'h0, cpu_ram_we, cpu_err}, 32'h0);
      cpu_req = 1'b0; cpu_priv = 1'b0;
    end

    // R6 DMA checking disabled
    cfg_rd(CTRL, rd); chk("R6 ctrl reset", rd, 32'h0);
    for (int blk = 0; blk < NBLK; blk++) begin
      int port;
      port = blk % ND;
      @(negedge clk);
      dma_req = '0; dma_req[port] = 1'b1;
      dma_addr[port*AW +: AW] = blk_addr(blk);
      #2 chk("R6 dma off pass", {29'h0, dma_ram_we}, {29'h0, dma_req});
    end
    @(negedge clk); dma_req = '0;
    #2 chk("R6 no irq", {31'h0, irq}, 32'h0);
    cfg_rd(STAT, rd); chk("R6 no status", rd, 32'h0);

    // R7 R8 DMA checking enabled, per-block sweep
    cfg_wr(CTRL, 32'h1);
    cfg_rd(CTRL, rd); chk("R6 ctrl readback", rd, 32'h1);
    for (int blk = 0; blk < NBLK; blk++) begin
      int port;
      logic p;
      port = (blk + 1) % ND;
      p = pat[blk];
      @(negedge clk);
      dma_req = '0; dma_req[port] = 1'b1;
      dma_addr[port*AW +: AW] = blk_addr(blk);
      #2 chk("R7 dma we", {31'h0, dma_ram_we[port]}, {31'h0, ~p});
      @(negedge clk);
      dma_req = '0;
      #2 chk("R7 irq", {31'h0, irq}, {31'h0, p});
      if (p) begin
        cfg_rd(STAT, rd);  chk("R7 status", rd, 32'h1);
        cfg_rd(FADDR, rd); chk("R8 fault addr", rd, {21'h0, blk_addr(blk)});
        cfg_rd(FID, rd);   chk("R8 fault id", rd, 32'(port));
        cfg_wr(STAT, 32'h1);
        #2 chk("R9 clear irq", {31'h0, irq}, 32'h0);
      end
    end

    // R8 simultaneous faults: lowest port wins (blocks 1,2,4 protected)
    @(negedge clk);
    dma_req = 3'b110;
    dma_addr[1*AW +: AW] = AW'(2*32 + 5);
    dma_addr[2*AW +: AW] = AW'(1*32 + 9);
    @(negedge clk);
    dma_req = '0;
    cfg_rd(FID, rd);   chk("R8 priority id", rd, 32'h1);
    cfg_rd(FADDR, rd); chk("R8 priority addr", rd, 32'd69);

    // R9 later fault does not overwrite
    @(negedge clk);
    dma_req = 3'b001;
    dma_addr[0*AW +: AW] = AW'(4*32 + 17);
    @(negedge clk);
    dma_req = '0;
    cfg_rd(FID, rd);   chk("R9 held id", rd, 32'h1);
    cfg_rd(FADDR, rd); chk("R9 held addr", rd, 32'd69);
    chk("R9 irq held", {31'h0, irq}, 32'h1);

    // R9 clear colliding with new fault
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CAW'(STAT); cfg_wdata = 32'h1;
    dma_req = 3'b100;
    dma_addr[2*AW +: AW] = AW'(32*32 + 3);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; dma_req = '0;
    #2 chk("R9 collide irq", {31'h0, irq}, 32'h1);
    cfg_rd(FID, rd);   chk("R9 collide id", rd, 32'h2);
    cfg_rd(FADDR, rd); chk("R9 collide addr", rd, 32'd1027);
    cfg_wr(STAT, 32'h1);
    #2 chk("R9 final clear", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule